// File: doc/BRIEF.md
# Inter-Processor Interrupt Send Command Dispatcher

This block sits behind the per-core command window of an inter-processor interrupt unit. Software writes a 64-bit send command to one of three command offsets, either as a single 64-bit write or as two 32-bit writes (low half first, then high half). Once the whole command is held, the block turns it into exactly one 32-bit store request toward a target core. The request carries the core id, a 16-bit register address inside that core and 32 bits of data.

The three command kinds differ only in how the address and data are built. An interrupt send writes a one-hot vector word to the target's interrupt-set register and pulses that core's request line. A mailbox send stores a data word into one of eight 32-bit mailbox slots. An arbitrary send stores a data word at any 16-bit address. For the two data-carrying kinds, a 4-bit byte mask in the command clears chosen data bytes. A one-entry buffer holds the outgoing request until the fabric accepts it, and the command port stalls while that buffer is occupied. Commands aimed at a core id outside the configured core count are discarded with a one-cycle error flag.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset `req_valid`, `irq_pulse` and `err_pulse` are 0 and `cmd_ready` is 1.
- R2: The target core id is command bits [25:16]. A command whose id is not below `NUM_CORES` produces no request and no `irq_pulse`, and raises `err_pulse` for exactly one cycle.
- R3: An interrupt send (command offset 0x40) yields address 0x1008 and data equal to 1 shifted left by command bits [4:0]. In the cycle the request first appears, `irq_pulse` has only the bit of the target core set, and that bit lasts one cycle.
- R4: A mailbox send (command offset 0x48) yields address 0x1020 plus (command bits [15:0] AND 0x001C).
- R5: An arbitrary send (command offset 0x158) yields address equal to command bits [15:0].
- R6: For mailbox and arbitrary sends the data is command bits [63:32], with byte i (bits 8i+7..8i) forced to zero whenever command bit 27+i is 1. The mask does not act on interrupt sends.
- R7: With `cmd_wide` = 0, a write to the command offset stores the low half (data bits [31:0]) and dispatches nothing; a later write to offset+4 supplies the high half and dispatches. With `cmd_wide` = 1, a write to the command offset carries all 64 bits and dispatches at once.
- R8: While `req_valid` is 1 and `req_ready` is 0, the request fields hold steady and `cmd_ready` is 0; a request leaves on the edge where `req_valid` and `req_ready` are both 1.
- R9: Accepted writes to any other offset produce no request and no flag.
- R10: A dispatched request shows `req_valid` = 1 in the cycle right after the edge that accepted the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command write present |
| cmd_ready | output | 1 | Command write can be accepted |
| cmd_addr | input | OFS_W | Byte offset of the command write |
| cmd_wide | input | 1 | 1: 64-bit write, 0: 32-bit write on bits [31:0] |
| cmd_wdata | input | 64 | Write data |
| req_valid | output | 1 | Outgoing store request present |
| req_ready | input | 1 | Fabric accepts the store request |
| req_core | output | CORE_W | Target core id |
| req_addr | output | 16 | Register address inside the target |
| req_data | output | 32 | Store data |
| irq_pulse | output | NUM_CORES | One-cycle interrupt request per target core |
| err_pulse | output | 1 | One-cycle flag for a dropped out-of-range command |

## Verification
On every cycle the assertions check that a waiting request keeps its fields, that the command port is closed while the buffer is full, that a new request only follows an accepted write, that the interrupt pulse is at most one-hot, never coincides with the error flag and always goes with a one-hot store to the interrupt-set register, and that no buffered request names an absent core. The exact address and data each command kind produces, the byte masking, the split-write ordering, the dropping of unknown offsets and the one-cycle length of the flags depend on the command's content, so only the bench's directed and random scenarios, compared against its own model, show them.

// File: rtl/ipi_disp_pkg.sv
// Package: shared kinds, request record and the decode helpers of the
// send command dispatcher. Assumes 64-bit command words and 16-bit
// target register addresses.
package ipi_disp_pkg;

    typedef enum logic [1:0] {
        KIND_IRQ  = 2'd0,
        KIND_MAIL = 2'd1,
        KIND_ANY  = 2'd2
    } send_kind_e;

    localparam int NUM_KINDS = 3;

    localparam logic [15:0] IRQ_SET_ADDR = 16'h1008;
    localparam logic [15:0] MBOX_BASE    = 16'h1020;

    // Command window offset of each kind
    function automatic logic [15:0] kind_offset(input int k);
        case (k)
            0:       return 16'h0040;
            1:       return 16'h0048;
            default: return 16'h0158;
        endcase
    endfunction

    // Clear each data byte whose mask bit (command bits 30:27) is set
    function automatic logic [31:0] masked_payload(input logic [63:0] w);
        logic [31:0] d;
        d = w[63:32];
        for (int b = 0; b < 4; b++) begin
            if (w[27 + b]) d[b*8 +: 8] = 8'h00;
        end
        return d;
    endfunction

endpackage

// File: rtl/ipi_cmd_capture.sv
// Command capture: decodes the write offset, keeps the low half of a
// split command per kind and reports a complete 64-bit command in the
// cycle of the completing write. Assumes at most one kind matches an
// offset and that the low half is written before the high half.
module ipi_cmd_capture
    import ipi_disp_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [OFS_W-1:0] addr,
    input  logic             wide,
    input  logic [63:0]      wdata,
    output logic             launch,
    output send_kind_e       kind,
    output logic [63:0]      word
);

    logic [NUM_KINDS-1:0] hit_lo;
    logic [NUM_KINDS-1:0] hit_hi;
    logic [31:0]          low_q [NUM_KINDS];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        localparam logic [OFS_W-1:0] BASE = OFS_W'(kind_offset(k));

        assign hit_lo[k] = (addr == BASE);
        assign hit_hi[k] = (addr == BASE + OFS_W'(4)) && !wide;

        // Hold the low half of a split command for this kind
        always_ff @(posedge clk) begin
            if (!rst_n)
                low_q[k] <= '0;
            else if (fire && hit_lo[k] && !wide)
                low_q[k] <= wdata[31:0];
        end
    end

    // Select the completing kind and assemble the full command
    always_comb begin
        launch = 1'b0;
        kind   = KIND_IRQ;
        word   = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            if (fire && ((hit_lo[k] && wide) || hit_hi[k])) begin
                launch = 1'b1;
                kind   = send_kind_e'(k);
                word   = wide ? wdata : {wdata[31:0], low_q[k]};
            end
        end
    end

endmodule

// File: rtl/ipi_cmd_decode.sv
// Command decoder: turns a complete command word of a given kind into
// target id, register address and store data, and tells whether the id
// names an existing core. Purely combinational.
module ipi_cmd_decode
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 10
) (
    input  send_kind_e        kind,
    input  logic [63:0]       word,
    output logic [CORE_W-1:0] core,
    output logic [15:0]       raddr,
    output logic [31:0]       rdata,
    output logic              in_range
);

    localparam int ID_LSB = 16;

    assign core     = word[ID_LSB +: CORE_W];
    assign in_range = (32'(core) < NUM_CORES);

    // Form address and data per send kind
    always_comb begin
        case (kind)
            KIND_IRQ: begin
                raddr = IRQ_SET_ADDR;
                rdata = 32'd1 << word[4:0];
            end
            KIND_MAIL: begin
                raddr = MBOX_BASE + (word[15:0] & 16'h001C);
                rdata = masked_payload(word);
            end
            default: begin
                raddr = word[15:0];
                rdata = masked_payload(word);
            end
        endcase
    end

endmodule

// File: rtl/ipi_req_slot.sv
// One-entry output buffer: loads a request, presents it with valid and
// keeps it unchanged until the consumer takes it. Assumes load is only
// raised while the slot is empty.
module ipi_req_slot #(
    parameter int CORE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CORE_W-1:0] in_core,
    input  logic [15:0]       in_addr,
    input  logic [31:0]       in_data,
    input  logic              take,
    output logic              full,
    output logic [CORE_W-1:0] out_core,
    output logic [15:0]       out_addr,
    output logic [31:0]       out_data
);

    // Occupancy flag
    always_ff @(posedge clk) begin
        if (!rst_n)    full <= 1'b0;
        else if (load) full <= 1'b1;
        else if (take) full <= 1'b0;
    end

    // Payload registers, written only on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_core <= '0;
            out_addr <= '0;
            out_data <= '0;
        end else if (load) begin
            out_core <= in_core;
            out_addr <= in_addr;
            out_data <= in_data;
        end
    end

endmodule

// File: rtl/ipi_cmd_dispatch.sv
// Top: accepts send command writes, captures full 64-bit commands,
// decodes them into one 32-bit store request held in a one-entry
// buffer, pulses the target's interrupt line for interrupt sends and
// flags commands aimed at missing cores. The command port is closed
// while the buffer holds a request.
module ipi_cmd_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 10,
    parameter int OFS_W     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [OFS_W-1:0]     cmd_addr,
    input  logic                 cmd_wide,
    input  logic [63:0]          cmd_wdata,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [CORE_W-1:0]    req_core,
    output logic [15:0]          req_addr,
    output logic [31:0]          req_data,
    output logic [NUM_CORES-1:0] irq_pulse,
    output logic                 err_pulse
);

    logic              fire;
    logic              launch;
    send_kind_e        kind;
    logic [63:0]       word;
    logic [CORE_W-1:0] dec_core;
    logic [15:0]       dec_addr;
    logic [31:0]       dec_data;
    logic              dec_ok;
    logic              slot_full;
    logic              load;
    logic [NUM_CORES-1:0] irq_next;

    assign cmd_ready = !slot_full;
    assign fire      = cmd_valid && cmd_ready;
    assign load      = launch && dec_ok;
    assign req_valid = slot_full;

    ipi_cmd_capture #(.OFS_W(OFS_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .addr   (cmd_addr),
        .wide   (cmd_wide),
        .wdata  (cmd_wdata),
        .launch (launch),
        .kind   (kind),
        .word   (word)
    );

    ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_decode (
        .kind     (kind),
        .word     (word),
        .core     (dec_core),
        .raddr    (dec_addr),
        .rdata    (dec_data),
        .in_range (dec_ok)
    );

    ipi_req_slot #(.CORE_W(CORE_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_core  (dec_core),
        .in_addr  (dec_addr),
        .in_data  (dec_data),
        .take     (req_ready),
        .full     (slot_full),
        .out_core (req_core),
        .out_addr (req_addr),
        .out_data (req_data)
    );

    // Per-core interrupt request for an accepted interrupt send
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++)
            irq_next[c] = load && (kind == KIND_IRQ) && (dec_core == CORE_W'(c));
    end

    // Register the one-cycle interrupt and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= '0;
            err_pulse <= 1'b0;
        end else begin
            irq_pulse <= irq_next;
            err_pulse <= launch && !dec_ok;
        end
    end

endmodule

// File: rtl/ipi_cmd_dispatch_chk.sv
// Checker: cycle-level properties of the dispatcher's ports, bound to
// every instance of the top module.
module ipi_cmd_dispatch_chk #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [CORE_W-1:0]    req_core,
    input logic [15:0]          req_addr,
    input logic [31:0]          req_data,
    input logic [NUM_CORES-1:0] irq_pulse,
    input logic                 err_pulse
);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_core) && $stable(req_addr) && $stable(req_data)));

    // R8
    port_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cmd_ready);

    // R10
    rise_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(cmd_valid && cmd_ready));

    // R3
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse));

    // R3
    irq_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |-> (req_valid && req_addr == 16'h1008 && $onehot(req_data)));

    // R2
    err_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (irq_pulse == '0));

    // R2
    core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (32'(req_core) < NUM_CORES));

endmodule

bind ipi_cmd_dispatch ipi_cmd_dispatch_chk #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .irq_pulse (irq_pulse),
    .err_pulse (err_pulse)
);

// File: tb/ipi_cmd_dispatch_test.sv
// Bench: directed corner cases plus seeded random commands, compared
// against a model written from the requirements.
module ipi_cmd_dispatch_test;

    localparam int NC     = 4;
    localparam int CORE_W = 10;
    localparam int OFS_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [OFS_W-1:0]  cmd_addr = '0;
    logic              cmd_wide = 1'b0;
    logic [63:0]       cmd_wdata = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [CORE_W-1:0] req_core;
    logic [15:0]       req_addr;
    logic [31:0]       req_data;
    logic [NC-1:0]     irq_pulse;
    logic              err_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ipi_cmd_dispatch #(.NUM_CORES(NC), .CORE_W(CORE_W), .OFS_W(OFS_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_wide(cmd_wide), .cmd_wdata(cmd_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_addr(req_addr), .req_data(req_data), .irq_pulse(irq_pulse),
        .err_pulse(err_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Model: offset per kind 0 irq, 1 mailbox, 2 arbitrary
    function automatic logic [11:0] base_of(input int k);
        return (k == 0) ? 12'h040 : (k == 1) ? 12'h048 : 12'h158;
    endfunction

    function automatic logic [31:0] exp_data(input int k, input logic [63:0] c);
        logic [31:0] d;
        if (k == 0) return 32'd1 << c[4:0];
        d = c[63:32];
        for (int b = 0; b < 4; b++) if (c[27 + b]) d[8*b +: 8] = 8'h00;
        return d;
    endfunction

    function automatic logic [15:0] exp_addr(input int k, input logic [63:0] c);
        if (k == 0) return 16'h1008;
        if (k == 1) return 16'h1020 + (c[15:0] & 16'h001C);
        return c[15:0];
    endfunction

    // One accepted write; returns at the negedge after the accepting edge
    task automatic put(input logic [11:0] a, input logic [63:0] d, input logic w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_wdata = d; cmd_wide = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send(input int k, input logic [63:0] c, input logic w);
        if (w) begin
            put(base_of(k), c, 1'b1);
        end else begin
            put(base_of(k), {32'hDEAD_BEEF, c[31:0]}, 1'b0);
            check(!req_valid && !err_pulse && irq_pulse == '0,
                  "R7 low half alone", {62'd0, err_pulse, req_valid}, 64'd0);
            put(base_of(k) + 12'd4, {32'h0, c[63:32]}, 1'b0);
        end
    endtask

    // Compare the result of a dispatched command, then drain it
    task automatic expect_and_drain(input int k, input logic [63:0] c, input int hold);
        int core;
        logic [NC-1:0] exp_irq;
        core = int'(c[25:16]);
        if (core >= NC) begin
            check(err_pulse && !req_valid && irq_pulse == '0, "R2 out-of-range drop",
                  {61'd0, err_pulse, req_valid, |irq_pulse}, 64'd4);
            @(negedge clk);
            check(!err_pulse && !req_valid, "R2 error lasts one cycle",
                  {62'd0, err_pulse, req_valid}, 64'd0);
            return;
        end
        exp_irq = (k == 0) ? NC'(1) << core : '0;
        check(req_valid, "R10 request after accept", {63'd0, req_valid}, 64'd1);
        check(req_core == CORE_W'(core), "R2 core id", 64'(req_core), 64'(core));
        check(req_addr == exp_addr(k, c),
              (k == 0) ? "R3 irq addr" : (k == 1) ? "R4 mailbox addr" : "R5 any addr",
              64'(req_addr), 64'(exp_addr(k, c)));
        check(req_data == exp_data(k, c), (k == 0) ? "R3 vector data" : "R6 masked data",
              64'(req_data), 64'(exp_data(k, c)));
        check(irq_pulse == exp_irq && !err_pulse, "R3 irq pulse",
              64'(irq_pulse), 64'(exp_irq));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(req_valid && !cmd_ready && req_data == exp_data(k, c) &&
                  req_addr == exp_addr(k, c), "R8 hold while stalled",
                  64'(req_data), 64'(exp_data(k, c)));
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check(!req_valid && cmd_ready && irq_pulse == '0, "R8 release",
              {62'd0, req_valid, cmd_ready}, 64'd1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] c;
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!req_valid && irq_pulse == '0 && !err_pulse && cmd_ready, "R1 reset",
              {60'd0, |irq_pulse, err_pulse, req_valid, cmd_ready}, 64'd1);

        // R3 interrupt send, vector 31, core 3, wide
        c = 64'hFFFF_FFFF_7803_001F;
        send(0, c, 1'b1); expect_and_drain(0, c, 2);
        // R3 interrupt send split, vector 0, mask bits ignored
        c = {32'h1234_5678, 32'h7801_0000};
        send(0, c, 1'b0); expect_and_drain(0, c, 0);
        // R4 R6 mailbox: slot bits 0x1C, mask clears bytes 0 and 2
        c = {32'hA1B2_C3D4, 32'h2802_FFFF};
        send(1, c, 1'b1); expect_and_drain(1, c, 1);
        // R5 R6 arbitrary split, all bytes masked
        c = {32'hCAFE_F00D, 32'h7800_BEEF};
        send(2, c, 1'b0); expect_and_drain(2, c, 0);
        // R2 core id equal to NUM_CORES and maximum id
        c = {32'h1111_1111, 32'h0004_0005};
        send(1, c, 1'b1); expect_and_drain(1, c, 0);
        c = {32'h1111_1111, 32'h03FF_0005};
        send(0, c, 1'b0); expect_and_drain(0, c, 0);

        // R9 writes to unused offsets
        put(12'h050, 64'hFFFF_FFFF_0001_0001, 1'b1);
        check(!req_valid && !err_pulse && irq_pulse == '0, "R9 unused offset",
              {62'd0, err_pulse, req_valid}, 64'd0);
        put(12'h15C, 64'h0, 1'b1);
        check(!req_valid && !err_pulse, "R9 wide write at high offset",
              {62'd0, err_pulse, req_valid}, 64'd0);

        // R8 stall: second command waits while the first is buffered
        c = 64'h0000_0000_0001_0003;
        send(0, c, 1'b1);
        fork
            send(2, 64'h0102_0304_0002_1234, 1'b1);
            begin
                for (int i = 0; i < 3; i++) begin
                    check(req_valid && req_data == 32'h8 && !cmd_ready,
                          "R8 stall keeps first request", 64'(req_data), 64'h8);
                    @(negedge clk);
                end
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
            end
        join
        expect_and_drain(2, 64'h0102_0304_0002_1234, 0);

        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            int k;
            logic [9:0] id;
            k = int'($urandom_range(2, 0));
            c = {$urandom, $urandom};
            id = ($urandom_range(9, 0) == 0) ? 10'($urandom) : 10'($urandom_range(NC, 0));
            c[25:16] = id;
            send(k, c, 1'($urandom));
            expect_and_drain(k, c, int'($urandom_range(3, 0)));
        end
        finish_run();
    end

endmodule